// File: doc/BRIEF.md
# Processor Status Word Register

This block holds the status word of a 32-bit CPU core. The word carries four condition flags (zero, sign, overflow, carry) and a saturation flag that stays set until software clears it. It also holds three control bits: a maskable-interrupt disable, an exception-in-progress marker and a non-maskable-interrupt-in-service marker. Only the low eight bits are live. The upper bits always read as zero and are never stored.

The execute stage drives a flag update strobe in any cycle. The strobe comes with a per-flag write mask, new flag values and a qualifier that marks saturating arithmetic. A load-to-status instruction drives a write port that replaces the whole live byte on the next clock edge. Event pulses record NMI acknowledgement and exception entry. The block gives the interrupt logic a single enable. That enable is held low while a status load that involves the disable bit is in flight, so no interrupt can slip in between the load and the moment its value takes effect.

Top module: `psw_flag_reg`

## Requirements
- R1: After reset the word reads 0x00000021 (disable bit 5 set, zero flag bit 0 set) and `int_enable` is low.
- R2: When `sr_wr_en` is high, the word read after the next rising edge equals the low eight bits of `sr_wr_data`, with zeros above them.
- R3: When `flag_upd_en` is high, each condition flag whose `flag_wr_mask` bit is 1 takes the matching `flag_new` bit, and the other flags keep their value. Both vectors use the order bit 0 zero, bit 1 sign, bit 2 overflow, bit 3 carry, which matches word bits 0 to 3.
- R4: A flag update with `sat_op` high, mask bit 2 set and `flag_new` bit 2 equal to 1 sets the saturation flag (word bit 4).
- R5: Once set, the saturation flag stays set through any later flag update. A flag update without that setting condition never changes it. Only a status write clears it.
- R6: A status write in the same cycle as a flag update, an NMI pulse or an exception pulse wins for every bit: the word becomes exactly the written byte.
- R7: `nmi_ack` sets word bit 7 and `exc_entry` sets word bit 6. Neither pulse changes any other bit.
- R8: Outside a status write cycle, `int_enable` is high exactly when word bit 5 and word bit 7 are both 0.
- R9: In a status write cycle, `int_enable` is low if word bit 5 or `sr_wr_data` bit 5 is 1.
- R10: Word bit 6 (exception in progress) has no influence on `int_enable`.
- R11: Word bits 31 to 8 always read 0, whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sr_wr_en | input | 1 | Load-to-status write strobe |
| sr_wr_data | input | WORD_W | Value to load into the word |
| flag_upd_en | input | 1 | Condition flag update strobe |
| flag_wr_mask | input | 4 | Per-flag write mask (0 zero, 1 sign, 2 overflow, 3 carry) |
| flag_new | input | 4 | New flag values, same order as the mask |
| sat_op | input | 1 | Marks the update as coming from a saturating instruction |
| nmi_ack | input | 1 | NMI acknowledged pulse |
| exc_entry | input | 1 | Exception entry pulse |
| psw_q | output | WORD_W | Current status word |
| int_enable | output | 1 | Maskable interrupts may be acknowledged |

## Verification
The bench builds the block with its default parameters: a 32-bit word and a reset value of 0x21. The wide word lets the bench push nonzero data into bits 31 to 8 and confirm that it never appears. Starting from the non-trivial reset value, the first status write runs while the disable bit is still set, which exercises the write-cycle interrupt gate from the very first cycle. A behavioural model, driven with both directed and pseudo-random strobe mixes, then checks the sticky saturation flag and the write-over-update priority on every clock.

// File: rtl/psw_pkg.sv
package psw_pkg;
   localparam int LIVE_BITS = 8;
   localparam int NUM_CC    = 4;
   localparam int BIT_Z     = 0;
   localparam int BIT_S     = 1;
   localparam int BIT_OV    = 2;
   localparam int BIT_CY    = 3;
   localparam int BIT_SAT   = 4;
   localparam int BIT_ID    = 5;
   localparam int BIT_EP    = 6;
   localparam int BIT_NP    = 7;

   typedef struct packed {
      logic np;
      logic ep;
      logic id;
      logic sat;
      logic [NUM_CC-1:0] cc;
   } psw_live_t;
endpackage

// File: rtl/psw_cc_update.sv
module psw_cc_update #(
   parameter int NUM_CC = 4,
   parameter int OV_IDX = 2
) (
   input  logic              upd_en,
   input  logic [NUM_CC-1:0] mask,
   input  logic [NUM_CC-1:0] new_val,
   input  logic [NUM_CC-1:0] cur_cc,
   input  logic              cur_sat,
   input  logic              sat_op,
   output logic [NUM_CC-1:0] nxt_cc,
   output logic              nxt_sat
);
   initial begin
      if (OV_IDX >= NUM_CC) $error("psw_cc_update: OV_IDX outside flag vector");
   end

   for (genvar i = 0; i < NUM_CC; i++) begin : g_cc
      assign nxt_cc[i] = (upd_en && mask[i]) ? new_val[i] : cur_cc[i];
   end

   // sticky: only ever ORs in a new saturation event
   assign nxt_sat = cur_sat | (upd_en & sat_op & mask[OV_IDX] & new_val[OV_IDX]);
endmodule

// File: rtl/psw_event_bits.sv
module psw_event_bits (
   input  logic cur_np,
   input  logic cur_ep,
   input  logic nmi_ack,
   input  logic exc_entry,
   output logic nxt_np,
   output logic nxt_ep
);
   assign nxt_np = cur_np | nmi_ack;
   assign nxt_ep = cur_ep | exc_entry;
endmodule

// File: rtl/psw_irq_gate.sv
module psw_irq_gate (
   input  logic id,
   input  logic np,
   input  logic wr_active,
   input  logic wr_id,
   output logic int_enable
);
   logic wr_block;
   assign wr_block   = wr_active & (id | wr_id);
   assign int_enable = ~id & ~np & ~wr_block;
endmodule

// File: rtl/psw_flag_reg.sv
module psw_flag_reg
   import psw_pkg::*;
#(
   parameter int                WORD_W      = 32,
   parameter logic [WORD_W-1:0] RESET_VALUE = 'h21
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sr_wr_en,
   input  logic [WORD_W-1:0]    sr_wr_data,
   input  logic                 flag_upd_en,
   input  logic [NUM_CC-1:0]    flag_wr_mask,
   input  logic [NUM_CC-1:0]    flag_new,
   input  logic                 sat_op,
   input  logic                 nmi_ack,
   input  logic                 exc_entry,
   output logic [WORD_W-1:0]    psw_q,
   output logic                 int_enable
);
   localparam int PAD_W = WORD_W - LIVE_BITS;
   localparam logic [LIVE_BITS-1:0] RST_LIVE = RESET_VALUE[LIVE_BITS-1:0];

   initial begin
      if (WORD_W < LIVE_BITS) $error("psw_flag_reg: WORD_W below live width");
      if ((RESET_VALUE >> LIVE_BITS) != 0) $error("psw_flag_reg: reset value sets reserved bits");
   end

   psw_live_t live_q, live_d, upd_w;
   logic [NUM_CC-1:0] cc_nxt;
   logic              sat_nxt, np_nxt, ep_nxt;

   psw_cc_update #(.NUM_CC(NUM_CC), .OV_IDX(BIT_OV)) u_cc (
      .upd_en (flag_upd_en),
      .mask   (flag_wr_mask),
      .new_val(flag_new),
      .cur_cc (live_q.cc),
      .cur_sat(live_q.sat),
      .sat_op (sat_op),
      .nxt_cc (cc_nxt),
      .nxt_sat(sat_nxt)
   );

   psw_event_bits u_evt (
      .cur_np   (live_q.np),
      .cur_ep   (live_q.ep),
      .nmi_ack  (nmi_ack),
      .exc_entry(exc_entry),
      .nxt_np   (np_nxt),
      .nxt_ep   (ep_nxt)
   );

   psw_irq_gate u_gate (
      .id        (live_q.id),
      .np        (live_q.np),
      .wr_active (sr_wr_en),
      .wr_id     (sr_wr_data[BIT_ID]),
      .int_enable(int_enable)
   );

   always_comb begin
      upd_w.np  = np_nxt;
      upd_w.ep  = ep_nxt;
      upd_w.id  = live_q.id;
      upd_w.sat = sat_nxt;
      upd_w.cc  = cc_nxt;
      // status load overrides every other source
      live_d = sr_wr_en ? psw_live_t'(sr_wr_data[LIVE_BITS-1:0]) : upd_w;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q <= psw_live_t'(RST_LIVE);
      else        live_q <= live_d;
   end

   if (PAD_W > 0) begin : g_pad
      logic unused_hi;
      assign unused_hi = ^sr_wr_data[WORD_W-1:LIVE_BITS];
      assign psw_q = {{PAD_W{1'b0}}, live_q};
   end else begin : g_nopad
      assign psw_q = live_q;
   end
endmodule

// File: rtl/psw_flag_reg_chk.sv
module psw_flag_reg_chk #(
   parameter int WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [7:0]        wr_low,
   input logic              upd_en,
   input logic              sat_op,
   input logic              ov_mask,
   input logic              ov_new,
   input logic              nmi_ack,
   input logic              exc_entry,
   input logic [WORD_W-1:0] psw,
   input logic              int_en
);
   logic sat_set;
   assign sat_set = upd_en & sat_op & ov_mask & ov_new;

   assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      psw[WORD_W-1:8] == '0);

   assert_write_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> psw[7:0] == $past(wr_low));

   assert_sat_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_set && !wr_en) |=> psw[4]);

   assert_sat_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !sat_set) |=> psw[4] == $past(psw[4]));

   assert_nmi_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_ack && !wr_en) |=> psw[7]);

   assert_exc_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_entry && !wr_en) |=> psw[6]);

   assert_enable_rule_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |-> int_en == (!psw[5] && !psw[7]));

   assert_write_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (psw[5] || wr_low[5])) |-> !int_en);
endmodule

bind psw_flag_reg psw_flag_reg_chk #(.WORD_W(WORD_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (sr_wr_en),
   .wr_low   (sr_wr_data[7:0]),
   .upd_en   (flag_upd_en),
   .sat_op   (sat_op),
   .ov_mask  (flag_wr_mask[2]),
   .ov_new   (flag_new[2]),
   .nmi_ack  (nmi_ack),
   .exc_entry(exc_entry),
   .psw      (psw_q),
   .int_en   (int_enable)
);

// File: tb/psw_flag_reg_tb.sv
module psw_flag_reg_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        sr_wr_en;
   logic [31:0] sr_wr_data;
   logic        flag_upd_en;
   logic [3:0]  flag_wr_mask;
   logic [3:0]  flag_new;
   logic        sat_op;
   logic        nmi_ack;
   logic        exc_entry;
   logic [31:0] psw_q;
   logic        int_enable;

   int checks = 0;
   int errors = 0;
   logic [7:0] m;

   always #(CLK_PERIOD/2) clk = ~clk;

   psw_flag_reg dut_i (
      .clk(clk), .rst_n(rst_n), .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data),
      .flag_upd_en(flag_upd_en), .flag_wr_mask(flag_wr_mask), .flag_new(flag_new),
      .sat_op(sat_op), .nmi_ack(nmi_ack), .exc_entry(exc_entry),
      .psw_q(psw_q), .int_enable(int_enable)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle();
      sr_wr_en = 0; sr_wr_data = 0; flag_upd_en = 0; flag_wr_mask = 0;
      flag_new = 0; sat_op = 0; nmi_ack = 0; exc_entry = 0;
   endtask

   // one clock: drive, compare against model, advance model
   task automatic cyc(string tag, logic wr, logic [31:0] wd, logic upd,
                      logic [3:0] msk, logic [3:0] nv, logic sat,
                      logic nmi, logic exc);
      logic exp_ie;
      sr_wr_en = wr; sr_wr_data = wd; flag_upd_en = upd; flag_wr_mask = msk;
      flag_new = nv; sat_op = sat; nmi_ack = nmi; exc_entry = exc;
      #1;
      exp_ie = !m[5] && !m[7] && !(wr && (m[5] || wd[5]));
      chk({tag, " word"}, psw_q, {24'h0, m});
      chk("R11 upper bits", {8'h0, psw_q[31:8]}, 32'h0);
      chk({tag, " int_enable"}, {31'h0, int_enable}, {31'h0, exp_ie});
      if (wr) m = wd[7:0];
      else begin
         for (int i = 0; i < 4; i++) if (upd && msk[i]) m[i] = nv[i];
         if (upd && sat && msk[2] && nv[2]) m[4] = 1'b1;
         if (nmi) m[7] = 1'b1;
         if (exc) m[6] = 1'b1;
      end
      @(negedge clk);
      idle();
      #1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      idle();
      rst_n = 0;
      m = 8'h21;
      repeat (3) @(negedge clk);
      #1;
      chk("R1 reset word", psw_q, 32'h21);
      chk("R1 reset int_enable", {31'h0, int_enable}, 32'h0);
      rst_n = 1;
      @(negedge clk); #1;

      cyc("R9", 1, 32'h0, 0, 0, 0, 0, 0, 0);
      chk("R2 load zero", psw_q, 32'h0);
      chk("R8 enable after load", {31'h0, int_enable}, 32'h1);
      cyc("R11", 1, 32'hABCDEF0F, 0, 0, 0, 0, 0, 0);
      chk("R11 high write dropped", psw_q, 32'h0F);
      cyc("R3", 0, 0, 1, 4'b0101, 4'b0000, 0, 0, 0);
      chk("R3 masked update", psw_q, 32'h0A);
      cyc("R4", 0, 0, 1, 4'b0100, 4'b0100, 1, 0, 0);
      chk("R4 sat set", psw_q, 32'h1E);
      cyc("R5", 0, 0, 1, 4'b1111, 4'b0000, 0, 0, 0);
      chk("R5 sat sticky", psw_q, 32'h10);
      cyc("R5", 0, 0, 1, 4'b0100, 4'b0000, 1, 0, 0);
      chk("R5 sat kept", psw_q, 32'h10);
      cyc("R6", 1, 32'h0, 1, 4'b1111, 4'b1111, 1, 1, 1);
      chk("R6 write wins", psw_q, 32'h0);
      cyc("R5", 0, 0, 1, 4'b0100, 4'b0100, 0, 0, 0);
      chk("R5 nonsat no set", psw_q, 32'h04);
      sr_wr_en = 1; sr_wr_data = 32'h20; #1;
      chk("R9 incoming disable", {31'h0, int_enable}, 32'h0);
      cyc("R9", 1, 32'h20, 0, 0, 0, 0, 0, 0);
      cyc("R2", 1, 32'h00, 0, 0, 0, 0, 0, 0);
      cyc("R7", 0, 0, 0, 0, 0, 0, 0, 1);
      chk("R7 exception bit", psw_q, 32'h40);
      chk("R10 ep no block", {31'h0, int_enable}, 32'h1);
      cyc("R7", 0, 0, 0, 0, 0, 0, 1, 0);
      chk("R7 nmi bit", psw_q, 32'hC0);
      chk("R8 nmi blocks", {31'h0, int_enable}, 32'h0);
      cyc("R6", 1, 32'h0, 0, 0, 0, 0, 1, 0);
      chk("R6 write over nmi", psw_q, 32'h0);

      for (int n = 0; n < 400; n++) begin
         logic [31:0] r;
         r = $urandom;
         cyc("R3", r[2:0] == 3'b000, $urandom, r[3], r[7:4], r[11:8], r[12],
             r[17:13] == 5'b0, r[22:18] == 5'b0);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule